// File: doc/BRIEF.md
# Framebuffer Fetch Controller

This block pulls pixel words out of a framebuffer held in memory and pushes them into the pixel FIFO that feeds the display timing path. Software supplies a framebuffer base address, the frame length in 32-bit words (width × height × bits per pixel / 32), a burst size written as word count minus one (eight words is the usual choice), and a FIFO fill threshold. The threshold is normally the FIFO depth minus three more than twice the burst size, so two bursts can still land after the check. An enable bit lets fetching run. A separate DMA reset bit discards all fetch progress.

Reads go out as bursts over a simple request/grant port. The request, address and length are held until the grant arrives. Read beats then come back on a valid strobe and pass straight into the FIFO. A burst is launched only while the FIFO occupancy reported by the FIFO is at or below the threshold and no earlier burst is still open. The final burst of a frame is cut short to the words that remain. After the last word of the frame, the next burst starts again at the base address.

Top module: `fbuf_fetch`

## Requirements
- R1: While `rst_n` is low, `mem_req`, `fifo_wr`, `frame_done` and `busy` are all 0.
- R2: The cycle after an idle cycle (`busy` = 0) in which `cfg_enable` = 1, `cfg_dma_reset` = 0, `cfg_frame_words` ≠ 0 and `fifo_level` ≤ `cfg_threshold`, `mem_req` rises. In every other case no new request is raised.
- R3: While `mem_req` = 1 and `mem_gnt` = 0, `mem_req`, `mem_addr` and `mem_len_m1` hold their values into the next cycle.
- R4: `mem_len_m1` is the word count minus one. The word count is `cfg_burst_m1`+1, or the number of words still left in the frame when that is smaller.
- R5: `mem_addr` is a byte address. A frame's first burst uses `cfg_base`. Each later burst starts 4 × (previous burst's word count) higher. The FIFO receives the words in address order.
- R6: Each `mem_rvalid` beat of a granted burst raises `fifo_wr` in the same cycle, with `fifo_wdata` = `mem_rdata`. A `mem_rvalid` with no open burst produces no `fifo_wr`.
- R7: `frame_done` pulses together with the `fifo_wr` of the frame's last word. The following burst starts at `cfg_base` with the full `cfg_frame_words` count.
- R8: `busy` is 1 from the launch of a burst until its last beat is accepted. Clearing `cfg_enable` lets an open burst finish, and then no further request is raised.
- R9: In the cycle after `cfg_dma_reset` = 1, `busy` and `mem_req` are 0. Beats of the abandoned burst are dropped. The next burst starts at `cfg_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Fetch enable |
| cfg_dma_reset | input | 1 | Synchronous clear of all fetch state |
| cfg_base | input | ADDR_W | Framebuffer base byte address |
| cfg_frame_words | input | FW_W | Frame length in words |
| cfg_burst_m1 | input | BL_W | Burst size minus one |
| cfg_threshold | input | LVL_W | Highest FIFO occupancy that still allows a launch |
| fifo_level | input | LVL_W | Current FIFO occupancy |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_len_m1 | output | BL_W | Burst words minus one |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DATA_W | Read beat data |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | DATA_W | FIFO write data |
| frame_done | output | 1 | Last word of frame written |
| busy | output | 1 | A burst is open |

## Verification
The hardest case to reach from the ports is a DMA reset that lands in the middle of a burst's data phase while the memory side keeps returning beats. Those beats must be dropped, and the fresh request must wait until the responder has finished with the old burst. The bench waits until `busy` is high with `mem_req` low, pulses the reset, and lets its responder deliver the rest of the abandoned burst. It then confirms that the next grant goes to the base address. The threshold stall is reached by stopping the FIFO drain until occupancy climbs past a small threshold. It is also reached by pairing truncated and oversized bursts with short frames so that wraps happen often.

// File: rtl/fbuf_fetch.sv
`timescale 1ns/1ps
module fbuf_fetch #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 512,
  parameter int FW_W       = 24,
  parameter int BL_W       = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_dma_reset,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [FW_W-1:0]   cfg_frame_words,
  input  logic [BL_W-1:0]   cfg_burst_m1,
  input  logic [LVL_W-1:0]  cfg_threshold,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BL_W-1:0]   mem_len_m1,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              frame_done,
  output logic              busy
);
  localparam int CNT_W = BL_W + 1;
  localparam int AL    = $clog2(DATA_W / 8);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} st_t;
  st_t st;

  logic [ADDR_W-1:0] next_addr, addr_q;
  logic [FW_W-1:0]   words_left;
  logic              at_start, last_q;
  logic [BL_W-1:0]   len_q;
  logic [CNT_W-1:0]  beats_left;

  logic [FW_W-1:0]   left_now, bw_ext, n_words;
  logic [ADDR_W-1:0] addr_now;
  logic              go, fire;

  assign left_now = at_start ? cfg_frame_words : words_left;
  assign addr_now = at_start ? cfg_base : next_addr;
  assign bw_ext   = FW_W'({1'b0, cfg_burst_m1}) + FW_W'(1);
  assign n_words  = (left_now < bw_ext) ? left_now : bw_ext;
  assign go       = (st == S_IDLE) && cfg_enable && !cfg_dma_reset &&
                    (cfg_frame_words != '0) && (fifo_level <= cfg_threshold);
  assign fire     = (st == S_DATA) && mem_rvalid;

  assign mem_req    = (st == S_REQ);
  assign mem_addr   = addr_q;
  assign mem_len_m1 = len_q;
  assign fifo_wr    = fire;
  assign fifo_wdata = mem_rdata;
  assign frame_done = fire && (beats_left == CNT_W'(1)) && last_q;
  assign busy       = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      at_start   <= 1'b1;
      words_left <= '0;
      next_addr  <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      last_q     <= 1'b0;
      beats_left <= '0;
    end else if (cfg_dma_reset) begin
      st         <= S_IDLE;
      at_start   <= 1'b1;
      beats_left <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st         <= S_REQ;
          addr_q     <= addr_now;
          len_q      <= BL_W'(n_words - FW_W'(1));
          beats_left <= CNT_W'(n_words);
          next_addr  <= addr_now + (ADDR_W'(n_words) << AL);
          words_left <= left_now - n_words;
          at_start   <= (left_now == n_words);
          last_q     <= (left_now == n_words);
        end
        S_REQ: if (mem_gnt) st <= S_DATA;
        S_DATA: if (mem_rvalid) begin
          beats_left <= beats_left - CNT_W'(1);
          if (beats_left == CNT_W'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !mem_req && !busy);

  assert_launch_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(cfg_enable) && !$past(busy) &&
                       ($past(fifo_level) <= $past(cfg_threshold)));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !cfg_dma_reset |=>
      mem_req && $stable(mem_addr) && $stable(mem_len_m1));

  assert_len_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_len_m1 <= $past(cfg_burst_m1));

  assert_wr_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> busy && !mem_req);

  assert_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> fifo_wr);

  assert_clear_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dma_reset |=> !busy && !mem_req);
endmodule

// File: tb/fbuf_fetch_tb.sv
`timescale 1ns/1ps
module fbuf_fetch_tb;
  localparam int AW = 32, DW = 32, DEPTH = 512, FWW = 24, BLW = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_enable, cfg_dma_reset;
  logic [AW-1:0] cfg_base;
  logic [FWW-1:0] cfg_frame_words;
  logic [BLW-1:0] cfg_burst_m1;
  logic [LW-1:0] cfg_threshold, fifo_level;
  logic mem_req, mem_gnt, mem_rvalid, fifo_wr, frame_done, busy;
  logic [AW-1:0] mem_addr;
  logic [BLW-1:0] mem_len_m1;
  logic [DW-1:0] mem_rdata, fifo_wdata;

  fbuf_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_dma_reset(cfg_dma_reset),
    .cfg_base(cfg_base), .cfg_frame_words(cfg_frame_words), .cfg_burst_m1(cfg_burst_m1),
    .cfg_threshold(cfg_threshold), .fifo_level(fifo_level), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_len_m1(mem_len_m1), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .frame_done(frame_done), .busy(busy));

  int checks = 0, failures = 0, cyc = 0;
  int lvl = 0;
  bit drain_en = 0, stray_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  bit m_req = 0, m_fs = 1, m_lastf = 0;
  int m_beats = 0, m_len = 0, m_left = 0;
  logic [AW-1:0] m_addr = '0, m_next = '0, m_baddr = '0;

  int resp_beats = 0, gnt_wait = 0;
  logic [AW-1:0] resp_addr = '0;

  bit p_req = 0, p_gnt = 0, p_dr = 0;
  logic [AW-1:0] p_addr = '0;
  logic [BLW-1:0] p_len = '0;

  int hs_count = 0, hs_len = 0, fd_count = 0, wr_seen = 0;
  logic [AW-1:0] hs_addr = '0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000 ^ {a[9:2], 24'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step;
    bit exp_wr, exp_busy, exp_fd, drain_now, s_req;
    logic [AW-1:0] s_addr;
    logic [BLW-1:0] s_len;
    int left, n;
    logic [AW-1:0] a;
    s_req = mem_req;
    mem_gnt = s_req && resp_beats == 0 && gnt_wait == 0 && rst_n;
    if (resp_beats > 0) begin
      mem_rvalid = lfsr[0] | lfsr[1];
      mem_rdata = pat(resp_addr);
    end else begin
      mem_rvalid = stray_en & lfsr[2];
      mem_rdata = {16'hDEAD, lfsr};
    end
    fifo_level = LW'(lvl);
    drain_now = drain_en && lvl > 0 && lfsr[3];
    #1;
    exp_busy = m_req || m_beats > 0;
    exp_wr = (m_beats > 0) && mem_rvalid;
    exp_fd = exp_wr && m_beats == 1 && m_lastf;
    chk(mem_req === m_req, "R2", "mem_req", mem_req, m_req);
    if (m_req) begin
      chk(mem_addr === m_addr, "R5", "mem_addr", mem_addr, m_addr);
      chk(int'(mem_len_m1) == m_len - 1, "R4", "mem_len_m1", mem_len_m1, m_len - 1);
    end
    chk(busy === exp_busy, "R8", "busy", busy, exp_busy);
    chk(fifo_wr === exp_wr, "R6", "fifo_wr", fifo_wr, exp_wr);
    if (exp_wr) chk(fifo_wdata === pat(m_baddr), "R5", "fifo_wdata", fifo_wdata, pat(m_baddr));
    chk(frame_done === exp_fd, "R7", "frame_done", frame_done, exp_fd);
    if (rst_n && p_req && !p_gnt && !p_dr)
      chk(mem_req === 1'b1 && mem_addr === p_addr && mem_len_m1 === p_len,
          "R3", "held request addr", mem_addr, p_addr);
    if (fifo_wr === 1'b1) wr_seen++;
    p_req = mem_req; p_gnt = mem_gnt; p_dr = cfg_dma_reset;
    p_addr = mem_addr; p_len = mem_len_m1;
    s_addr = mem_addr; s_len = mem_len_m1;
    @(posedge clk);
    cyc++;
    if (!rst_n) begin
      m_req = 0; m_beats = 0; m_fs = 1; m_lastf = 0;
    end else if (cfg_dma_reset) begin
      m_req = 0; m_beats = 0; m_fs = 1;
    end else if (m_req) begin
      if (mem_gnt) begin m_req = 0; m_beats = m_len; m_baddr = m_addr; end
    end else if (m_beats > 0) begin
      if (mem_rvalid) begin m_beats--; m_baddr += 4; end
    end else if (cfg_enable && cfg_frame_words != 0 && lvl <= int'(cfg_threshold)) begin
      left = m_fs ? int'(cfg_frame_words) : m_left;
      a = m_fs ? cfg_base : m_next;
      n = int'(cfg_burst_m1) + 1;
      if (left < n) n = left;
      m_req = 1; m_addr = a; m_len = n; m_next = a + AW'(4 * n);
      m_left = left - n; m_fs = (m_left == 0); m_lastf = m_fs;
    end
    if (!rst_n) begin
      resp_beats = 0; gnt_wait = 0;
    end else if (s_req && mem_gnt) begin
      resp_beats = int'(s_len) + 1; resp_addr = s_addr;
      hs_count++; hs_addr = s_addr; hs_len = int'(s_len) + 1;
      gnt_wait = int'(lfsr[5:4]) % 3;
    end else begin
      if (s_req && gnt_wait > 0) gnt_wait--;
      if (mem_rvalid && resp_beats > 0) begin resp_beats--; resp_addr += 4; end
    end
    if (!rst_n) lvl = 0;
    else lvl = lvl + int'(exp_wr) - int'(drain_now);
    if (exp_fd) fd_count++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_hs(input int h0);
    for (int i = 0; i < 2000 && hs_count == h0; i++) step();
  endtask

  task automatic wait_data;
    for (int i = 0; i < 2000 && !(busy && !mem_req); i++) step();
  endtask

  task automatic pulse_clear;
    cfg_dma_reset = 1; step(); cfg_dma_reset = 0;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int h0, f0;
    rst_n = 0; cfg_enable = 0; cfg_dma_reset = 0; cfg_base = '0;
    cfg_frame_words = '0; cfg_burst_m1 = '0; cfg_threshold = '0;
    fifo_level = '0; mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0;
    @(negedge clk);
    cfg_enable = 1; cfg_frame_words = 20; cfg_burst_m1 = 7;
    run(4);
    // R1: reset state
    chk(mem_req === 1'b0 && busy === 1'b0, "R1", "req/busy in reset", {mem_req, busy}, 0);
    chk(fifo_wr === 1'b0 && frame_done === 1'b0, "R1", "wr/done in reset", {fifo_wr, frame_done}, 0);
    rst_n = 1;
    cfg_base = 32'h0000_1000;
    cfg_threshold = LW'(DEPTH - (2 * 8 + 3));
    drain_en = 1;
    // R4/R7: 20-word frame in 8,8,4 bursts with wrap
    run(400);
    chk(fd_count >= 2, "R7", "frames completed", fd_count, 2);

    // R2: threshold stall with drain stopped
    cfg_enable = 0;
    for (int i = 0; i < 4000 && (lvl > 0 || busy); i++) step();
    cfg_threshold = 20; drain_en = 0; cfg_enable = 1;
    run(300);
    chk(lvl > 20 && lvl <= 28, "R2", "level after stall", lvl, 28);
    chk(busy === 1'b0 && mem_req === 1'b0, "R2", "stalled idle", {busy, mem_req}, 0);

    // R8: enable cleared mid-burst
    cfg_threshold = LW'(DEPTH - (2 * 8 + 3)); drain_en = 1;
    wait_data();
    cfg_enable = 0;
    h0 = hs_count;
    run(80);
    chk(busy === 1'b0, "R8", "busy after disable", busy, 0);
    chk(hs_count == h0, "R8", "requests after disable", hs_count, h0);

    // R6: stray beats with no burst open
    stray_en = 1; wr_seen = 0;
    run(50);
    chk(wr_seen == 0, "R6", "stray writes", wr_seen, 0);
    stray_en = 0;

    // R9: clear during data phase
    cfg_enable = 1;
    run(30);
    wait_data();
    pulse_clear();
    chk(busy === 1'b0 && mem_req === 1'b0, "R9", "idle after clear", {busy, mem_req}, 0);
    h0 = hs_count;
    wait_hs(h0);
    chk(hs_addr === cfg_base, "R9", "restart address", hs_addr, cfg_base);

    // R2: zero frame length never launches
    pulse_clear();
    cfg_frame_words = 0;
    run(20);
    h0 = hs_count;
    run(50);
    chk(hs_count == h0 && busy === 1'b0, "R2", "zero frame requests", hs_count, h0);

    // R7: single-word bursts, 3-word frames
    cfg_base = 32'h0000_2000; cfg_frame_words = 3; cfg_burst_m1 = 0;
    pulse_clear();
    f0 = fd_count;
    run(200);
    chk(fd_count > f0 + 2, "R7", "short frames done", fd_count - f0, 3);

    // R4: burst larger than frame is cut to frame length
    cfg_base = 32'h0000_3000; cfg_frame_words = 5; cfg_burst_m1 = 15;
    pulse_clear();
    h0 = hs_count;
    wait_hs(h0);
    chk(hs_len == 5, "R4", "truncated burst", hs_len, 5);
    chk(hs_addr === 32'h0000_3000, "R5", "frame start", hs_addr, 32'h3000);
    h0 = hs_count;
    wait_hs(h0);
    chk(hs_addr === 32'h0000_3000, "R7", "wrap to base", hs_addr, 32'h3000);
    run(20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule